// File: doc/BRIEF.md
# Prefix-Extended Add-With-Carry Execution Unit

This unit executes one instruction class of a small processor: a 16-bit add that also adds the carry flag. The processor has eight 24-bit general registers. Each 16-bit instruction word is decoded in the cycle it is presented. The unit returns the register indices to read, takes the two operand values back, and drives a write of the 24-bit destination in that same cycle. The condition flags sit in a register inside the unit and change at the clock edge that ends the cycle.

Two kinds of word reach the unit. An immediate prefix word carries 13 immediate bits and writes nothing. An add word that follows one or two prefixes replaces its second operand with an immediate built from them, and the source register becomes the first operand. The add comes in three forms: one that always executes and sets the flags, one that executes only while carry is set, and one that executes only while carry is clear. The conditional forms never touch the flags. When the add sits in a branch delay slot, any pending prefix is discarded and the register form is used.

Top module: `adc_exec_unit`

## Requirements
- R1: An add word has 001110 in bits 15:10, the destination index in bits 9:7, a sub-operation in bits 6:3 and the source index in bits 2:0; rd_sel and rs_sel show bits 9:7 and 2:0, and a write goes to rd_sel.
- R2: With no prefix pending, an executed add writes rd_val[15:0] + rs_val[15:0] + C into bits 15:0.
- R3: Every write has bits 23:16 equal to zero.
- R4: After one prefix, an executed add writes rs_val[15:0] + zero-extended 13-bit immediate + C.
- R5: After two prefixes, the immediate is {low 3 bits of the earlier prefix, 13 bits of the later prefix}, and the add writes rs_val[15:0] + that immediate + C.
- R6: After three or more prefixes in a row, only the last two form the immediate.
- R7: A prefix word has 110 in bits 15:13 and the immediate in bits 12:0; it writes nothing and leaves the flags unchanged.
- R8: Any valid word that is not a prefix, add or not, clears the pending prefixes, and so does reset.
- R9: An add word with delay_slot high uses the register form of R2 and clears the pending prefixes.
- R10: Sub-operation 1001 always executes and loads flags = {C,V,Z,N} in bits 3..0. C is the carry out of bit 15, V is the signed 16-bit overflow, Z is set for a zero 16-bit result and N is result bit 15. The new flags show on the output after the clock edge.
- R11: Sub-operation 0001 executes only when C=1 and 0101 only when C=0; a skipped form writes nothing; both leave the flags unchanged.
- R12: Any other sub-operation under the add opcode writes nothing and leaves the flags unchanged.
- R13: With instr_valid low there is no write, and the flags and pending prefixes do not change.
- R14: Reset clears the flags to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | instr carries a word to execute this cycle |
| instr | input | 16 | Instruction word |
| delay_slot | input | 1 | The word sits in a branch delay slot |
| rd_val | input | 24 | Value of the destination register (read at rd_sel) |
| rs_val | input | 24 | Value of the source register (read at rs_sel) |
| rd_sel | output | 3 | Destination register index, used for both the read and the write |
| rs_sel | output | 3 | Source register index |
| wr_en | output | 1 | Write the destination this cycle |
| wr_data | output | 24 | Value written to the destination |
| flags | output | 4 | {C,V,Z,N} condition flags |

## Verification
A wrong prefix count or a stale prefix value stays hidden until the next add word. That add then shows a wrong wr_data in the same cycle, so each prefix scenario ends with an add that reveals the state. A wrong flag register shows one cycle later, either as a wrong flags value or as a conditional form that executes when it should skip. The sequences therefore chain several adds, so that each carry produced is consumed by the next add. Reset is also applied with a prefix pending, and the first add after it must take the register form.

// File: rtl/adc_pkg.sv
package adc_pkg;
    localparam int IMM_W = 13;
    localparam int IDX_W = 3;
    localparam logic [5:0] MAJ_ADD   = 6'b001110;
    localparam logic [2:0] PFX_TAG   = 3'b110;
    localparam logic [3:0] SUB_ALWAYS = 4'b1001;
    localparam logic [3:0] SUB_IF_C   = 4'b0001;
    localparam logic [3:0] SUB_IF_NC  = 4'b0101;

    typedef struct packed {
        logic c;
        logic v;
        logic z;
        logic n;
    } flags_t;
endpackage

// File: rtl/adc_prefix_acc.sv
module adc_prefix_acc #(
    parameter int ALU_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic                     consume,
    input  logic [adc_pkg::IMM_W-1:0] push_imm,
    output logic                     has_imm,
    output logic [ALU_W-1:0]         imm
);
    import adc_pkg::*;
    localparam int HI_W = ALU_W - IMM_W;

    typedef struct packed {
        logic [1:0]       cnt;
        logic [HI_W-1:0]  older;
        logic [IMM_W-1:0] newer;
    } pfx_t;

    pfx_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.older = st_q.newer[HI_W-1:0];
            st_d.newer = push_imm;
            st_d.cnt   = (st_q.cnt == 2'd2) ? 2'd2 : st_q.cnt + 2'd1;
        end else if (consume) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign has_imm = (st_q.cnt != 2'd0);
    assign imm = (st_q.cnt == 2'd2) ? {st_q.older, st_q.newer}
                                    : {{HI_W{1'b0}}, st_q.newer};

    AST_PFX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !push) |=> (st_q.cnt == 2'd0)); // R8
    AST_PFX_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (push && st_q.cnt == 2'd2) |=> (st_q.older == $past(st_q.newer[HI_W-1:0]) && st_q.cnt == 2'd2)); // R6
endmodule

// File: rtl/adc_decode.sv
module adc_decode (
    input  logic                      valid,
    input  logic [15:0]               instr,
    input  logic                      c_flag,
    output logic                      is_pfx,
    output logic [adc_pkg::IMM_W-1:0] pfx_imm,
    output logic                      consume,
    output logic                      exec,
    output logic                      upd_flags,
    output logic [adc_pkg::IDX_W-1:0] rd_idx,
    output logic [adc_pkg::IDX_W-1:0] rs_idx
);
    import adc_pkg::*;
    logic       is_add;
    logic [3:0] sub;

    always_comb begin
        is_pfx    = valid && (instr[15:13] == PFX_TAG);
        is_add    = valid && (instr[15:10] == MAJ_ADD);
        sub       = instr[6:3];
        pfx_imm   = instr[IMM_W-1:0];
        rd_idx    = instr[9:7];
        rs_idx    = instr[2:0];
        consume   = valid && !is_pfx;
        upd_flags = is_add && (sub == SUB_ALWAYS);
        exec      = is_add && ((sub == SUB_ALWAYS) ||
                               (sub == SUB_IF_C  &&  c_flag) ||
                               (sub == SUB_IF_NC && !c_flag));
        if (!valid) assert (!exec && !is_pfx); // R13
    end
endmodule

// File: rtl/adc_adder.sv
module adc_adder #(
    parameter int ALU_W = 16
) (
    input  logic [ALU_W-1:0] a,
    input  logic [ALU_W-1:0] b,
    input  logic             cin,
    output logic [ALU_W-1:0] sum,
    output adc_pkg::flags_t  fl
);
    logic [ALU_W:0] wide;
    logic           c_into_msb;

    always_comb begin
        wide       = {1'b0, a} + {1'b0, b} + {{ALU_W{1'b0}}, cin};
        sum        = wide[ALU_W-1:0];
        c_into_msb = a[ALU_W-1] ^ b[ALU_W-1] ^ sum[ALU_W-1];
        fl.c       = wide[ALU_W];
        fl.v       = c_into_msb ^ wide[ALU_W];
        fl.z       = (sum == '0);
        fl.n       = sum[ALU_W-1];
    end
endmodule

// File: rtl/adc_exec_unit.sv
module adc_exec_unit #(
    parameter int REG_W = 24,
    parameter int ALU_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [15:0]      instr,
    input  logic             delay_slot,
    input  logic [REG_W-1:0] rd_val,
    input  logic [REG_W-1:0] rs_val,
    output logic [2:0]       rd_sel,
    output logic [2:0]       rs_sel,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_data,
    output logic [3:0]       flags
);
    import adc_pkg::*;
    localparam int TOP_W = REG_W - ALU_W;

    flags_t           fl_d, fl_q, add_fl;
    logic             is_pfx, consume, exec, upd_flags, has_imm, use_imm;
    logic [IMM_W-1:0] pfx_imm;
    logic [ALU_W-1:0] imm, op_a, op_b, sum;
    logic             unused_hi;

    assign unused_hi = ^{rd_val[REG_W-1:ALU_W], rs_val[REG_W-1:ALU_W]};

    adc_decode u_dec (
        .valid     (instr_valid),
        .instr     (instr),
        .c_flag    (fl_q.c),
        .is_pfx    (is_pfx),
        .pfx_imm   (pfx_imm),
        .consume   (consume),
        .exec      (exec),
        .upd_flags (upd_flags),
        .rd_idx    (rd_sel),
        .rs_idx    (rs_sel)
    );

    adc_prefix_acc #(.ALU_W(ALU_W)) u_pfx (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (is_pfx),
        .consume  (consume),
        .push_imm (pfx_imm),
        .has_imm  (has_imm),
        .imm      (imm)
    );

    always_comb begin
        use_imm = has_imm && !delay_slot;
        op_a    = use_imm ? rs_val[ALU_W-1:0] : rd_val[ALU_W-1:0];
        op_b    = use_imm ? imm               : rs_val[ALU_W-1:0];
    end

    adc_adder #(.ALU_W(ALU_W)) u_add (
        .a   (op_a),
        .b   (op_b),
        .cin (fl_q.c),
        .sum (sum),
        .fl  (add_fl)
    );

    always_comb begin
        fl_d = fl_q;
        if (upd_flags) fl_d = add_fl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign wr_en   = exec;
    assign wr_data = {{TOP_W{1'b0}}, sum};
    assign flags   = fl_q;

    AST_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data[REG_W-1:ALU_W] == '0)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(flags)); // R13
    AST_COND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[15:10] == MAJ_ADD && instr[6:3] != SUB_ALWAYS) |=> $stable(flags)); // R11
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[15:10] == MAJ_ADD && instr[6:3] == SUB_ALWAYS)
        |=> (flags[1] == ($past(wr_data[ALU_W-1:0]) == '0))); // R10
    AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[15:10] == MAJ_ADD && instr[6:3] == SUB_ALWAYS)
        |=> (flags[0] == $past(wr_data[ALU_W-1]))); // R10
    AST_PFX_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[15:13] == PFX_TAG) |-> !wr_en); // R7
endmodule

// File: tb/sim_adc_exec_unit.sv
module sim_adc_exec_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 27;

    typedef struct packed {
        logic [4:0]  req;
        logic        vld;
        logic        ds;
        logic [15:0] ins;
        logic [23:0] rdv;
        logic [23:0] rsv;
        logic        we;
        logic [23:0] dat;
        logic [3:0]  flg;
    } vec_t;

    // add r1,r2: 38CA always / 388A if C / 38AA if not C / 389A other sub-op
    // prefix words: C000 | imm13
    localparam vec_t VEC [NV] = '{
        '{5'd2,  1'b1, 1'b0, 16'h38CA, 24'hAB1234, 24'h000111, 1'b1, 24'h001345, 4'h0}, // R2 R3
        '{5'd10, 1'b1, 1'b0, 16'h38CA, 24'h12FFFF, 24'h000001, 1'b1, 24'h000000, 4'hA}, // R10 carry, zero
        '{5'd1,  1'b1, 1'b0, 16'h3BC8, 24'h007FFF, 24'h000000, 1'b1, 24'h008000, 4'h5}, // R1 r7, R10 overflow
        '{5'd11, 1'b1, 1'b0, 16'h388A, 24'h000010, 24'h000020, 1'b0, 24'h000000, 4'h5}, // R11 skip
        '{5'd11, 1'b1, 1'b0, 16'h38AA, 24'h000010, 24'h000020, 1'b1, 24'h000030, 4'h5}, // R11 exec
        '{5'd7,  1'b1, 1'b0, 16'hCABC, 24'h000000, 24'h000000, 1'b0, 24'h000000, 4'h5}, // R7
        '{5'd4,  1'b1, 1'b0, 16'h38CA, 24'h000005, 24'h00F000, 1'b1, 24'h00FABC, 4'h1}, // R4
        '{5'd7,  1'b1, 1'b0, 16'hDFFF, 24'h000000, 24'h000000, 1'b0, 24'h000000, 4'h1}, // R7
        '{5'd7,  1'b1, 1'b0, 16'hC001, 24'h000000, 24'h000000, 1'b0, 24'h000000, 4'h1}, // R7
        '{5'd5,  1'b1, 1'b0, 16'h38CA, 24'h000000, 24'h000010, 1'b1, 24'h00E011, 4'h1}, // R5
        '{5'd7,  1'b1, 1'b0, 16'hC002, 24'h000000, 24'h000000, 1'b0, 24'h000000, 4'h1}, // R7
        '{5'd7,  1'b1, 1'b0, 16'hC003, 24'h000000, 24'h000000, 1'b0, 24'h000000, 4'h1}, // R7
        '{5'd7,  1'b1, 1'b0, 16'hC004, 24'h000000, 24'h000000, 1'b0, 24'h000000, 4'h1}, // R7
        '{5'd6,  1'b1, 1'b0, 16'h38AA, 24'h000000, 24'h000100, 1'b1, 24'h006104, 4'h1}, // R6
        '{5'd7,  1'b1, 1'b0, 16'hC100, 24'h000000, 24'h000000, 1'b0, 24'h000000, 4'h1}, // R7
        '{5'd9,  1'b1, 1'b1, 16'h38CA, 24'h000002, 24'h000003, 1'b1, 24'h000005, 4'h0}, // R9
        '{5'd9,  1'b1, 1'b0, 16'h38CA, 24'h000001, 24'h000001, 1'b1, 24'h000002, 4'h0}, // R9 cleared
        '{5'd7,  1'b1, 1'b0, 16'hC050, 24'h000000, 24'h000000, 1'b0, 24'h000000, 4'h0}, // R7
        '{5'd8,  1'b1, 1'b0, 16'h0000, 24'h000001, 24'h000001, 1'b0, 24'h000000, 4'h0}, // R8 other op
        '{5'd8,  1'b1, 1'b0, 16'h38CA, 24'h000004, 24'h000004, 1'b1, 24'h000008, 4'h0}, // R8
        '{5'd12, 1'b1, 1'b0, 16'h389A, 24'h000001, 24'h000001, 1'b0, 24'h000000, 4'h0}, // R12
        '{5'd13, 1'b0, 1'b0, 16'hC123, 24'h000000, 24'h000000, 1'b0, 24'h000000, 4'h0}, // R13
        '{5'd13, 1'b1, 1'b0, 16'h38CA, 24'h000003, 24'h000003, 1'b1, 24'h000006, 4'h0}, // R13 no prefix
        '{5'd10, 1'b1, 1'b0, 16'h38CA, 24'h00FFFF, 24'h000002, 1'b1, 24'h000001, 4'h8}, // R10 carry
        '{5'd11, 1'b1, 1'b0, 16'h388A, 24'h000100, 24'h000200, 1'b1, 24'h000301, 4'h8}, // R11 exec, C in
        '{5'd11, 1'b1, 1'b0, 16'h38AA, 24'h000100, 24'h000200, 1'b0, 24'h000000, 4'h8}, // R11 skip
        '{5'd10, 1'b1, 1'b0, 16'h38CA, 24'h008000, 24'h008000, 1'b1, 24'h000001, 4'hC}  // R10 neg overflow
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic        delay_slot = 1'b0;
    logic [23:0] rd_val = '0;
    logic [23:0] rs_val = '0;
    logic [2:0]  rd_sel, rs_sel;
    logic        wr_en;
    logic [23:0] wr_data;
    logic [3:0]  flags;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_exec_unit u0 (
        .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid), .instr (instr),
        .delay_slot (delay_slot), .rd_val (rd_val), .rs_val (rs_val),
        .rd_sel (rd_sel), .rs_sel (rs_sel), .wr_en (wr_en), .wr_data (wr_data),
        .flags (flags)
    );

    task automatic check(input bit ok, input int req, input string what,
                         input logic [23:0] act, input logic [23:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive at the falling edge, sample the same-cycle outputs just before the
    // rising edge, then sample the flags just after it.
    task automatic step(input vec_t v);
        @(negedge clk);
        instr_valid = v.vld;
        delay_slot  = v.ds;
        instr       = v.ins;
        rd_val      = v.rdv;
        rs_val      = v.rsv;
        #(CLK_PERIOD / 2 - 1);
        check(wr_en == v.we, int'(v.req), "wr_en", {23'd0, wr_en}, {23'd0, v.we});
        if (v.we) begin
            check(wr_data == v.dat, int'(v.req), "wr_data", wr_data, v.dat);
            check(rd_sel == v.ins[9:7], 1, "rd_sel", {21'd0, rd_sel}, {21'd0, v.ins[9:7]}); // R1
            check(rs_sel == v.ins[2:0], 1, "rs_sel", {21'd0, rs_sel}, {21'd0, v.ins[2:0]}); // R1
        end
        @(posedge clk);
        #1;
        check(flags == v.flg, int'(v.req), "flags", {20'd0, flags}, {20'd0, v.flg});
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired (all requirements): actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(flags == 4'h0, 14, "reset flags", {20'd0, flags}, 24'd0);   // R14
        check(wr_en == 1'b0, 13, "idle wr_en", {23'd0, wr_en}, 24'd0);   // R13

        for (int i = 0; i < NV; i++) step(VEC[i]);

        // R8 R14: a pending prefix and set flags are both dropped by reset
        step('{5'd7, 1'b1, 1'b0, 16'hC00F, 24'h0, 24'h0, 1'b0, 24'h0, 4'hC});
        @(negedge clk);
        instr_valid = 1'b0;
        rst_n = 1'b0;
        #2;
        check(flags == 4'h0, 14, "flags in reset", {20'd0, flags}, 24'd0); // R14
        @(negedge clk);
        rst_n = 1'b1;
        step('{5'd8, 1'b1, 1'b0, 16'h38CA, 24'h000007, 24'h000009, 1'b1, 24'h000010, 4'h0}); // R8
        // R3: high operand bits never reach the result
        step('{5'd3, 1'b1, 1'b0, 16'h38CA, 24'hFF0001, 24'hFF0001, 1'b1, 24'h000002, 4'h0});  // R3

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule